// File: doc/BRIEF.md
# Coprocessor Context Restore Sequencer

This block is the host-side controller for an instruction that restores a coprocessor's saved context from memory. When `start` is pulsed, it checks the addressing-mode field of the instruction. If the mode is not allowed, it raises an emulator-exception flag and does nothing else.

For an accepted instruction it works through these steps:

1. It reads the format word at the resolved operand address and keeps the word's length field.
2. It writes the format word to the coprocessor's restore register, then reads that register back.
3. The code in the read-back value selects one of three paths:
   - Abort the coprocessor and flag a format error.
   - Finish at once, with no data moved.
   - Stream the saved context, one 32-bit word at a time, from memory into the coprocessor's operand register.

The memory side is a request/acknowledge read port. The coprocessor side is a request/acknowledge register bus with a 2-bit register select. Every access is held until it is acknowledged. Instruction decode, the address arithmetic and exception vectoring belong to the surrounding core. The address arrives already resolved, and `pc_out` gives the instruction pointer advanced past the operation word and its extension words.

Top module: `ctx_restore_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fmt_err`, `emu_exc`, `mem_req` and `rb_req` are all low.
- R2: A start whose mode field `ea_mode[5:3]` is 000, 001, 100 (predecrement) or 111 with `ea_mode[2:0]` above 3, or whose extension count exceeds 5, raises `emu_exc` for exactly one cycle. It makes no memory or register-bus access and gives no `done`.
- R3: For an accepted start, the first access is a memory read at `ea_addr`. The format word is `mem_rdata[15:0]`: its code is in bits 15:8 and its length in bytes is in bits 7:0.
- R4: Next, the format word, zero-extended, is written to the restore register (select 0), and then the restore register is read. The response code is `rb_rdata[15:8]`.
- R5: A response code of 0x02 causes a write of 0x0001 to the control register (select 1). Completion then carries `fmt_err`, and no operand write takes place.
- R6: A response code of 0x00 completes with no operand write and no `fmt_err`.
- R7: Any other response code causes ceil(length/4) transfers. Transfer k (counting from 0) reads memory at `ea_addr + 4*(k+1)` and writes that longword to the operand register (select 2), in order. A length of 0 moves nothing.
- R8: From the cycle after an accepted start, `pc_out` equals `pc_in + 2 + 2*ext_cnt`.
- R9: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start through the `done` cycle, and `fmt_err` is only ever high together with `done`.
- R10: A memory or register-bus request stays asserted, with its address, select and direction stable, until acknowledged. The two requests are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one restore instruction |
| ea_mode | input | 6 | Addressing-mode field: mode in bits 5:3, register in bits 2:0 |
| ext_cnt | input | 3 | Number of extension words following the operation word |
| ea_addr | input | 32 | Resolved operand address |
| pc_in | input | 32 | Address of the operation word |
| pc_out | output | 32 | Instruction pointer past the instruction |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fmt_err | output | 1 | Format-error exception flag, valid with `done` |
| emu_exc | output | 1 | Emulator-exception flag for a rejected start |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory read acknowledge |
| rb_req | output | 1 | Coprocessor register-bus request |
| rb_we | output | 1 | Register-bus write (1) or read (0) |
| rb_sel | output | 2 | Register select: 0 restore, 1 control, 2 operand |
| rb_wdata | output | 32 | Register-bus write data |
| rb_rdata | input | 32 | Register-bus read data |
| rb_ack | input | 1 | Register-bus acknowledge |

## Verification
The hardest situation to reach from the ports is a response code that disagrees with the fetched format word. The transfer count must come from the length byte fetched from memory, not from what the coprocessor answers.

The bench's coprocessor model returns a response code that is chosen independently of the format code in memory. It also stretches every handshake by a random number of cycles. This covers abort, empty and transfer paths against full-range lengths, including 0, 1, 4, 5 and 255.

// File: rtl/ctx_restore_pkg.sv
package ctx_restore_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WR_RST,
        ST_RD_RST,
        ST_ABORT,
        ST_XFER_RD,
        ST_XFER_WR,
        ST_FINISH
    } seq_state_e;

    localparam logic [1:0] SEL_RESTORE = 2'd0;
    localparam logic [1:0] SEL_CONTROL = 2'd1;
    localparam logic [1:0] SEL_OPERAND = 2'd2;

endpackage

// File: rtl/ctx_ea_check.sv
module ctx_ea_check #(
    parameter int ADDR_W  = 32,
    parameter int MAX_EXT = 5,
    parameter int EXT_W   = 3
) (
    input  logic [5:0]        ea_mode,
    input  logic [EXT_W-1:0]  ext_cnt,
    input  logic [ADDR_W-1:0] pc_in,
    output logic              ea_ok,
    output logic [ADDR_W-1:0] pc_next
);
    logic mode_ok;

    always_comb begin
        unique case (ea_mode[5:3])
            3'b010, 3'b011, 3'b101, 3'b110: mode_ok = 1'b1;
            3'b111:                         mode_ok = (ea_mode[2:0] <= 3'd3);
            default:                        mode_ok = 1'b0;
        endcase
    end

    assign ea_ok   = mode_ok && (int'(ext_cnt) <= MAX_EXT);
    assign pc_next = pc_in + ADDR_W'(2) + (ADDR_W'(ext_cnt) << 1);
endmodule

// File: rtl/ctx_xfer_counter.sv
module ctx_xfer_counter #(
    parameter int LEN_W = 8,
    parameter int BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             dec,
    output logic             cnt_zero,
    output logic             cnt_last
);
    localparam int SHIFT = $clog2(BYTES);
    localparam int CNT_W = LEN_W - SHIFT + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [LEN_W:0]   rounded;

    always_comb begin
        rounded = {1'b0, len} + (LEN_W+1)'(BYTES - 1);
        cnt_d   = cnt_q;
        if (load) begin
            cnt_d = CNT_W'(rounded >> SHIFT);
        end else if (dec && cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_zero = (cnt_q == '0);
    assign cnt_last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/ctx_restore_seq.sv
module ctx_restore_seq
    import ctx_restore_pkg::*;
#(
    parameter int          ADDR_W       = 32,
    parameter int          DATA_W       = 32,
    parameter int          LEN_W        = 8,
    parameter int          MAX_EXT      = 5,
    parameter logic [7:0]  CODE_INVALID = 8'h02,
    parameter logic [7:0]  CODE_EMPTY   = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [5:0]        ea_mode,
    input  logic [2:0]        ext_cnt,
    input  logic [ADDR_W-1:0] ea_addr,
    input  logic [ADDR_W-1:0] pc_in,
    output logic [ADDR_W-1:0] pc_out,
    output logic              busy,
    output logic              done,
    output logic              fmt_err,
    output logic              emu_exc,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              rb_req,
    output logic              rb_we,
    output logic [1:0]        rb_sel,
    output logic [DATA_W-1:0] rb_wdata,
    input  logic [DATA_W-1:0] rb_rdata,
    input  logic              rb_ack
);
    localparam int BYTES = DATA_W / 8;
    localparam int FMT_W = 16;

    typedef struct packed {
        seq_state_e         st;
        logic [ADDR_W-1:0]  addr;
        logic [FMT_W-1:0]   fmt;
        logic [DATA_W-1:0]  data;
        logic               err;
        logic               emu;
        logic [ADDR_W-1:0]  pc;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              ea_ok;
    logic [ADDR_W-1:0] pc_next;
    logic              cnt_load, cnt_dec, cnt_zero, cnt_last;
    logic [7:0]        resp_code;

    ctx_ea_check #(
        .ADDR_W (ADDR_W),
        .MAX_EXT(MAX_EXT),
        .EXT_W  (3)
    ) u_ea (
        .ea_mode(ea_mode),
        .ext_cnt(ext_cnt),
        .pc_in  (pc_in),
        .ea_ok  (ea_ok),
        .pc_next(pc_next)
    );

    ctx_xfer_counter #(
        .LEN_W(LEN_W),
        .BYTES(BYTES)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .len     (mem_rdata[LEN_W-1:0]),
        .dec     (cnt_dec),
        .cnt_zero(cnt_zero),
        .cnt_last(cnt_last)
    );

    assign resp_code = rb_rdata[15:8];

    always_comb begin
        r_d      = r_q;
        r_d.emu  = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (ea_ok) begin
                        r_d.st   = ST_FETCH;
                        r_d.addr = ea_addr;
                        r_d.pc   = pc_next;
                        r_d.err  = 1'b0;
                    end else begin
                        r_d.emu = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    r_d.fmt  = mem_rdata[FMT_W-1:0];
                    r_d.addr = r_q.addr + ADDR_W'(BYTES);
                    cnt_load = 1'b1;
                    r_d.st   = ST_WR_RST;
                end
            end
            ST_WR_RST: begin
                if (rb_ack) r_d.st = ST_RD_RST;
            end
            ST_RD_RST: begin
                if (rb_ack) begin
                    if (resp_code == CODE_INVALID) begin
                        r_d.st = ST_ABORT;
                    end else if (resp_code == CODE_EMPTY || cnt_zero) begin
                        r_d.st = ST_FINISH;
                    end else begin
                        r_d.st = ST_XFER_RD;
                    end
                end
            end
            ST_ABORT: begin
                if (rb_ack) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_FINISH;
                end
            end
            ST_XFER_RD: begin
                if (mem_ack) begin
                    r_d.data = mem_rdata;
                    r_d.addr = r_q.addr + ADDR_W'(BYTES);
                    r_d.st   = ST_XFER_WR;
                end
            end
            ST_XFER_WR: begin
                if (rb_ack) begin
                    cnt_dec = 1'b1;
                    r_d.st  = cnt_last ? ST_FINISH : ST_XFER_RD;
                end
            end
            ST_FINISH: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_req  = (r_q.st == ST_FETCH) || (r_q.st == ST_XFER_RD);
        mem_addr = r_q.addr;
        rb_req   = 1'b0;
        rb_we    = 1'b1;
        rb_sel   = SEL_RESTORE;
        rb_wdata = '0;
        unique case (r_q.st)
            ST_WR_RST: begin
                rb_req   = 1'b1;
                rb_wdata = DATA_W'(r_q.fmt);
            end
            ST_RD_RST: begin
                rb_req = 1'b1;
                rb_we  = 1'b0;
            end
            ST_ABORT: begin
                rb_req   = 1'b1;
                rb_sel   = SEL_CONTROL;
                rb_wdata = DATA_W'(1);
            end
            ST_XFER_WR: begin
                rb_req   = 1'b1;
                rb_sel   = SEL_OPERAND;
                rb_wdata = r_q.data;
            end
            default: ;
        endcase
    end

    assign busy    = (r_q.st != ST_IDLE);
    assign done    = (r_q.st == ST_FINISH);
    assign fmt_err = done && r_q.err;
    assign emu_exc = r_q.emu;
    assign pc_out  = r_q.pc;
endmodule

// File: rtl/ctx_restore_chk.sv
module ctx_restore_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fmt_err,
    input logic              emu_exc,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rb_req,
    input logic              rb_ack,
    input logic              rb_we,
    input logic [1:0]        rb_sel,
    input logic [DATA_W-1:0] rb_wdata
);
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> done);

    a_r9_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r2_emu_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        emu_exc |-> (!mem_req && !rb_req && !done && !busy));

    a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    a_r10_rb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_req && !rb_ack) |=> (rb_req && $stable(rb_sel) && $stable(rb_we)));

    a_r10_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, rb_req}));

    a_r5_abort_value: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_req && rb_we && rb_sel == 2'd1) |-> (rb_wdata == DATA_W'(1)));

    a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind ctx_restore_seq ctx_restore_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .fmt_err (fmt_err),
    .emu_exc (emu_exc),
    .mem_req (mem_req),
    .mem_ack (mem_ack),
    .mem_addr(mem_addr),
    .rb_req  (rb_req),
    .rb_ack  (rb_ack),
    .rb_we   (rb_we),
    .rb_sel  (rb_sel),
    .rb_wdata(rb_wdata)
);

// File: tb/ctx_restore_seq_tb.sv
module ctx_restore_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  ea_mode = '0;
    logic [2:0]  ext_cnt = '0;
    logic [31:0] ea_addr = '0;
    logic [31:0] pc_in = '0;
    logic [31:0] pc_out;
    logic        busy, done, fmt_err, emu_exc;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        rb_req, rb_we;
    logic [1:0]  rb_sel;
    logic [31:0] rb_wdata;
    logic [31:0] rb_rdata = '0;
    logic        rb_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [31:0] cur_ea;
    logic [15:0] cur_fmt;
    logic [7:0]  cur_resp;
    int n_mem, n_op, n_ctrl, n_rst_wr, n_rst_rd, op_bad, ctrl_bad;
    logic [31:0] first_addr, rst_wval;
    int mwait = 0;
    int rwait = 0;

    always #4 clk = ~clk;

    ctx_restore_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ea_mode(ea_mode),
        .ext_cnt(ext_cnt), .ea_addr(ea_addr), .pc_in(pc_in), .pc_out(pc_out),
        .busy(busy), .done(done), .fmt_err(fmt_err), .emu_exc(emu_exc),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .rb_req(rb_req), .rb_we(rb_we), .rb_sel(rb_sel),
        .rb_wdata(rb_wdata), .rb_rdata(rb_rdata), .rb_ack(rb_ack)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h3c5a, ~a[15:0]};
    endfunction

    function automatic bit mode_valid(input logic [5:0] m);
        bit memory_mode;
        memory_mode = (m[5:3] inside {3'b010, 3'b011, 3'b101, 3'b110});
        if (m[5:3] == 3'b111 && m[2:0] < 3'd4) memory_mode = 1'b1;
        return memory_mode;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (rst_n && mem_req) begin
            if (mwait == 0) begin
                mem_ack = 1'b1;
                mem_rdata = (mem_addr == cur_ea) ? {16'h0, cur_fmt} : pat(mem_addr);
                if (n_mem == 0) first_addr = mem_addr;
                n_mem++;
                mwait = $urandom % 3;
            end else begin
                mwait--;
            end
        end
    end

    always @(negedge clk) begin
        rb_ack = 1'b0;
        if (rst_n && rb_req) begin
            if (rwait == 0) begin
                rb_ack = 1'b1;
                case (rb_sel)
                    2'd0: begin
                        if (rb_we) begin
                            rst_wval = rb_wdata;
                            n_rst_wr++;
                        end else begin
                            rb_rdata = {16'h0, cur_resp, 8'h00};
                            n_rst_rd++;
                        end
                    end
                    2'd1: begin
                        n_ctrl++;
                        if (rb_wdata != 32'd1) ctrl_bad++;
                    end
                    default: begin
                        if (rb_wdata != pat(cur_ea + 32'(4 * (n_op + 1)))) op_bad++;
                        n_op++;
                    end
                endcase
                rwait = $urandom % 3;
            end else begin
                rwait--;
            end
        end
    end

    task automatic run_case(input logic [5:0] m, input logic [2:0] ext,
                            input logic [31:0] ea, input logic [31:0] pc,
                            input logic [7:0] code, input logic [7:0] len,
                            input logic [7:0] resp);
        bit exp_emu, saw_done, saw_emu, saw_err, timed_out;
        int exp_ops;
        @(posedge clk);
        n_mem = 0; n_op = 0; n_ctrl = 0; n_rst_wr = 0; n_rst_rd = 0;
        op_bad = 0; ctrl_bad = 0; first_addr = '0; rst_wval = '0;
        cur_ea = ea; cur_fmt = {code, len}; cur_resp = resp;
        @(negedge clk);
        ea_mode = m; ext_cnt = ext; ea_addr = ea; pc_in = pc; start = 1'b1;
        saw_done = 0; saw_emu = 0; saw_err = 0; timed_out = 1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (emu_exc) saw_emu = 1;
            if (done) begin
                saw_done = 1;
                saw_err = fmt_err;
            end
            if (saw_done || saw_emu) begin
                timed_out = 0;
                break;
            end
        end
        repeat (3) @(negedge clk);
        check(!timed_out, "R9 completion seen", 32'(timed_out), 32'd0);
        exp_emu = !mode_valid(m) || (ext > 3'd5);
        check(saw_emu == exp_emu, "R2 emulator flag", 32'(saw_emu), 32'(exp_emu));
        if (exp_emu) begin
            check(n_mem == 0 && n_rst_wr == 0 && n_rst_rd == 0 && n_op == 0 && n_ctrl == 0,
                  "R2 no bus activity", 32'(n_mem + n_rst_wr + n_rst_rd + n_op + n_ctrl), 32'd0);
            check(!saw_done, "R2 no done", 32'(saw_done), 32'd0);
        end else begin
            if (resp == 8'h02 || resp == 8'h00) exp_ops = 0;
            else exp_ops = (int'(len) + 3) / 4;
            check(first_addr == ea, "R3 fetch address", first_addr, ea);
            check(rst_wval == {16'h0, code, len} && n_rst_wr == 1 && n_rst_rd == 1,
                  "R4 restore write value", rst_wval, {16'h0, code, len});
            check(saw_err == (resp == 8'h02), "R5 format error flag",
                  32'(saw_err), 32'(resp == 8'h02));
            check(n_ctrl == ((resp == 8'h02) ? 1 : 0) && ctrl_bad == 0,
                  "R5 control abort write", 32'(n_ctrl), 32'(resp == 8'h02));
            if (resp == 8'h00) check(n_op == 0, "R6 empty no transfer", 32'(n_op), 32'd0);
            check(n_op == exp_ops, "R7 transfer count", 32'(n_op), 32'(exp_ops));
            check(op_bad == 0, "R7 transfer data order", 32'(op_bad), 32'd0);
            check(pc_out == pc + 32'd2 + 32'(ext) * 32'd2, "R8 pc advance",
                  pc_out, pc + 32'd2 + 32'(ext) * 32'd2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!busy && !done && !fmt_err && !emu_exc && !mem_req && !rb_req,
              "R1 reset state", {26'h0, busy, done, fmt_err, emu_exc, mem_req, rb_req}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !mem_req && !rb_req, "R1 idle after reset",
              {29'h0, busy, mem_req, rb_req}, 32'd0);

        run_case(6'b100_011, 3'd0, 32'h1000, 32'h400, 8'h11, 8'd8, 8'h11);
        run_case(6'b001_000, 3'd1, 32'h1000, 32'h400, 8'h11, 8'd8, 8'h11);
        run_case(6'b111_100, 3'd2, 32'h1000, 32'h400, 8'h11, 8'd8, 8'h11);
        run_case(6'b010_001, 3'd6, 32'h1000, 32'h400, 8'h11, 8'd8, 8'h11);
        run_case(6'b010_001, 3'd5, 32'h2000, 32'h500, 8'h11, 8'd8, 8'h02);
        run_case(6'b111_001, 3'd2, 32'h3000, 32'h600, 8'h11, 8'd20, 8'h00);
        run_case(6'b101_010, 3'd1, 32'h4000, 32'h700, 8'h02, 8'd0, 8'h33);
        run_case(6'b011_000, 3'd0, 32'h5000, 32'h800, 8'h00, 8'd1, 8'h40);
        run_case(6'b110_111, 3'd3, 32'h6000, 32'h900, 8'h40, 8'd4, 8'h40);
        run_case(6'b111_011, 3'd4, 32'h7000, 32'ha00, 8'h40, 8'd5, 8'h40);
        run_case(6'b010_000, 3'd0, 32'h8000, 32'hb00, 8'h40, 8'd255, 8'h41);

        for (int k = 0; k < 40; k++) begin
            logic [5:0] m;
            logic [7:0] rsel, resp_r;
            m = 6'($urandom);
            rsel = 8'($urandom % 4);
            resp_r = (rsel == 0) ? 8'h00 : (rsel == 1) ? 8'h02 : 8'($urandom);
            run_case(m, 3'($urandom % 7), {16'h0, 12'($urandom), 4'h0} + 32'h10000,
                     32'($urandom) & 32'hffff_fffe, 8'($urandom), 8'($urandom), resp_r);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule